// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a purely combinational two's-complement adder/subtractor. It takes two operands and an operation select and returns the sum or difference together with four condition flags: negative, zero, carry and overflow. After a subtraction the carry flag means "no borrow": it is 1 when the first operand is unsigned greater than or equal to the second. It is not set when a borrow occurred.

An optional carry-in is honoured only when its enable is high. With the enable high, addition computes `a + b + cin` and subtraction computes `a - b - 1 + cin`. With the enable low, the carry-in pin has no effect. The carry flag is always bit `WIDTH` of the internal one-bit-wider sum. The overflow flag is derived from the sign bits of the operands and the result. The unit is intended to feed a flag register that lives elsewhere, and it performs no storage of its own.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_sel` = 0, `result` equals `op_a + op_b` modulo 2^WIDTH, plus `carry_in` when `carry_in_en` = 1.
- R2: With `sub_sel` = 1, `result` equals `op_a - op_b` modulo 2^WIDTH when `carry_in_en` = 0, and `op_a - op_b - 1 + carry_in` when `carry_in_en` = 1.
- R3: `flag_n` equals bit WIDTH-1 (the sign bit) of `result`.
- R4: `flag_z` is 1 exactly when every bit of `result` is 0.
- R5: For addition, `flag_c` is the unsigned carry out of the top bit. Equivalently, it is 1 when both operand sign bits are 1, or when either operand sign bit is 1 and the result sign bit is 0.
- R6: For subtraction, `flag_c` is the inverted borrow. Equivalently, it is 1 when any of these holds: the minuend is negative and the subtrahend is non-negative; the minuend is negative and the result is non-negative; or the subtrahend is non-negative and the result is non-negative. With `carry_in_en` = 0, this means `flag_c` = 1 exactly when `op_a >= op_b` unsigned.
- R7: For addition, `flag_v` is 1 exactly when both operands have the same sign bit and the result sign bit differs from it.
- R8: For subtraction, `flag_v` is 1 exactly when the operands have different sign bits and the result sign bit differs from the sign bit of `op_a`.
- R9: When `carry_in_en` = 0, the value of `carry_in` has no effect on any output.
- R10: When `carry_in_en` = 1, `flag_c` is bit WIDTH of the WIDTH+1-bit sum `op_a + (sub_sel ? ~op_b : op_b) + carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend for subtraction) |
| op_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| carry_in_en | input | 1 | 1 makes the unit use `carry_in` |
| carry_in | input | 1 | Carry input, honoured only when enabled |
| result | output | WIDTH | Sum or difference |
| flag_n | output | 1 | Result sign bit |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Carry out (inverted borrow after subtraction) |
| flag_v | output | 1 | Signed overflow |

## Verification
The assertions check the same facts on every input change. The adder's carry out agrees with the sign-bit carry rule for both operations. The overflow flag agrees with the sign-bit overflow rule. A plain subtraction without carry-in sets carry exactly when there is no unsigned borrow. The zero and negative flags are never set together. Only the bench's scenarios can show that the arithmetic result itself is right. The same holds for the boundary operands 0, the largest positive value, the most negative value and all-ones. The bench also shows that the carry-in pin is ignored while its enable is low.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_sel,
  input  logic             carry_in_en,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [WIDTH:0]   sum_ext;

  // Subtraction is a + ~b + 1; the enabled carry-in replaces the implicit 1.
  assign b_eff   = sub_sel ? ~op_b : op_b;
  assign c_eff   = carry_in_en ? carry_in : sub_sel;
  assign sum_ext = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};

  assign result = sum_ext[MSB:0];
  assign flag_n = sum_ext[MSB];
  assign flag_z = ~|sum_ext[MSB:0];
  assign flag_c = sum_ext[WIDTH];

  logic sa, sb, sr;
  assign sa = op_a[MSB];
  assign sb = op_b[MSB];
  assign sr = sum_ext[MSB];

  assign flag_v = sub_sel ? ((sa != sb) && (sr != sa))
                          : ((sa == sb) && (sr != sa));

  logic rule_c;
  always_comb begin
    if (sub_sel)
      rule_c = (sa && !sb) || (sa && !sr) || (!sb && !sr);
    else
      rule_c = (sa && sb) || (sa && !sr) || (sb && !sr);
  end

  always_comb begin
    AST_ADD_CARRY_RULE: assert (sub_sel || (flag_c == rule_c));  // R5
    AST_SUB_CARRY_RULE: assert (!sub_sel || (flag_c == rule_c));  // R6
    AST_SUB_NO_BORROW: assert (!sub_sel || carry_in_en || (flag_c == (op_a >= op_b)));  // R6
    AST_ZERO_NOT_NEG: assert (!(flag_z && flag_n));  // R4
    AST_ADD_OVF_RESULT: assert (sub_sel || !flag_v || (op_a[MSB] != result[MSB]));  // R7
    AST_SUB_OVF_RESULT: assert (!sub_sel || !flag_v || (op_a[MSB] != result[MSB]));  // R8
  end
endmodule

// File: tb/addsub_flags_tb_top.sv
module addsub_flags_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic sub, cen, ci, n, z, c, v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_flags #(.WIDTH(W)) dut_i (
    .op_a(a), .op_b(b), .sub_sel(sub), .carry_in_en(cen), .carry_in(ci),
    .result(res), .flag_n(n), .flag_z(z), .flag_c(c), .flag_v(v)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sub=%0d cen=%0d ci=%0d actual=%h expected=%h",
               tag, a, b, sub, cen, ci, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ia, input logic [W-1:0] ib,
                       input logic isub, input logic icen, input logic ici);
    longint unsigned ua, ub, u;
    longint sa, sb, s;
    logic [W:0] u33;
    logic [W-1:0] er;
    logic cadd;
    @(negedge clk);
    a = ia; b = ib; sub = isub; cen = icen; ci = ici;
    #1;
    cadd = icen ? ici : 1'b0;
    ua = longint'(ia); ub = longint'(ib);
    sa = longint'($signed(ia)); sb = longint'($signed(ib));
    if (isub) begin
      u = ua + ((longint'(1) << W) - 1 - ub) + (icen ? longint'(ici) : 1);
      s = sa - sb - 1 + (icen ? longint'(ici) : 1);
    end else begin
      u = ua + ub + longint'(cadd);
      s = sa + sb + longint'(cadd);
    end
    u33 = u[W:0];
    er = u33[W-1:0];
    chk(isub ? "R2 result" : "R1 result", res, er);
    chk("R3 flag_n", {{(W-1){1'b0}}, n}, {{(W-1){1'b0}}, er[W-1]});
    chk("R4 flag_z", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, (er == '0)});
    if (icen)
      chk("R10 flag_c", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, u33[W]});
    else if (isub)
      chk("R6 flag_c", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, (ia >= ib)});
    else
      chk("R5 flag_c", {{(W-1){1'b0}}, c}, {{(W-1){1'b0}}, u33[W]});
    chk(isub ? "R8 flag_v" : "R7 flag_v", {{(W-1){1'b0}}, v},
        {{(W-1){1'b0}}, (s > 64'sh7FFFFFFF) || (s < -64'sh80000000)});
  endtask

  task automatic ignore_cin(input logic [W-1:0] ia, input logic [W-1:0] ib, input logic isub);
    logic [W-1:0] r0;
    logic [3:0] f0;
    @(negedge clk);
    a = ia; b = ib; sub = isub; cen = 1'b0; ci = 1'b0;
    #1;
    r0 = res; f0 = {n, z, c, v};
    ci = 1'b1;
    #1;
    chk("R9 result", res, r0);
    chk("R9 flags", {{(W-4){1'b0}}, n, z, c, v}, {{(W-4){1'b0}}, f0});
  endtask

  localparam logic [W-1:0] CORNERS [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  initial begin
    a = '0; b = '0; sub = 1'b0; cen = 1'b0; ci = 1'b0;
    #1;
    chk("R4 idle zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});
    chk("R1 idle result", res, '0);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int m = 0; m < 8; m++)
          apply(CORNERS[i], CORNERS[j], m[0], m[1], m[2]);
    apply(32'h1, 32'h1, 1'b1, 1'b0, 1'b0);
    apply(32'h0, 32'h1, 1'b1, 1'b0, 1'b0);
    apply(32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 1'b0);
    apply(32'h80000000, 32'h1, 1'b1, 1'b0, 1'b0);
    apply(32'hFFFFFFFF, 32'h0, 1'b0, 1'b1, 1'b1);
    ignore_cin(32'h12345678, 32'h9ABCDEF0, 1'b0);
    ignore_cin(32'h80000000, 32'h7FFFFFFF, 1'b1);
    void'($urandom(32'd2024));
    for (int k = 0; k < 1500; k++) begin
      logic [W-1:0] ra, rb;
      logic [2:0] mode;
      ra = $urandom(); rb = $urandom(); mode = 3'($urandom());
      if (mode == 3'd7) rb = ra;
      apply(ra, rb, mode[0], mode[1], mode[2]);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule